// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block is the shift/rotate datapath of a microcoded processor. It is purely combinational. It takes a source operand, a count operand, the old destination value, the incoming condition flags and a per-operation flag-write mask. In the same cycle it returns the merged destination value and the updated flags.

Seven operations are supported:

| Code | Operation |
|------|-----------|
| 0 | logical left shift |
| 1 | logical right shift |
| 2 | arithmetic right shift |
| 3 | plain rotate right |
| 4 | plain rotate left |
| 5 | rotate right through carry |
| 6 | rotate left through carry |
| 7 | no-op |

The operand size is chosen by a 2-bit code, where code k means 2^k bytes (1, 2, 4 or 8 bytes). Only the low bytes of the destination that match the size are replaced. Carry, extra-carry and overflow follow a rule specific to each operation. Zero, sign and parity are taken from the result.

There are no states and no transitions. The unit is a single combinational evaluation, and a microsequencer uses it in whichever cycle presents the operands. Flag vector layout, shared by the flag inputs, the flag outputs and the write mask:

| Bit | Flag |
|-----|------|
| 0 | carry |
| 1 | extra-carry |
| 2 | parity |
| 3 | zero |
| 4 | sign |
| 5 | overflow |

Top module: `sr_shift_rotate_unit`

## Requirements
- R1: The effective count is the count operand masked to 6 bits when the size code is 3 (8 bytes), and masked to 5 bits for every other size code. In the definitions below, W is the operand width in bits and c is the effective count.
- R2: When c is zero, the flag output equals the flag input. Rotates (codes 3 to 6) also return the destination unchanged. Shifts (codes 0 to 2) merge the unshifted source into the destination.
- R3: For size code k, destination bytes below 2^k take the result. All higher bytes pass through from the old destination.
- R4: When c is nonzero, each flag whose write-mask bit is set takes its new value. Each flag whose mask bit is clear keeps its old value. Extra-carry, when written, always equals the new carry.
- R5: Logical left shift (code 0) fills vacated bits with zeros. Carry is the last bit shifted out: source bit W−c, or 0 when c > W. Overflow is carry XOR result MSB.
- R6: Logical right shift (code 1) fills vacated bits with zeros. Carry is the last bit shifted out: source bit c−1, or 0 when c > W. Overflow is the source MSB.
- R7: Arithmetic right shift (code 2) fills vacated bits with the source sign bit. Carry is the last bit shifted out, which is the sign bit when c ≥ W. Overflow is cleared.
- R8: Plain rotate right (code 3) rotates by c mod W, with carry = result MSB and overflow = result MSB XOR result bit W−2. Plain rotate left (code 4) rotates by c mod W, with carry = result LSB and overflow = result MSB XOR result LSB.
- R9: Rotate right through carry (code 5) rotates the (W+1)-bit value {carry, source} right by c mod (W+1). The new carry is the bit that lands in the carry position. Overflow is incoming carry XOR source MSB.
- R10: Rotate left through carry (code 6) rotates {carry, source} left by c mod (W+1). The new carry is the bit that lands in the carry position. Overflow is result MSB XOR new carry.
- R11: Zero is set when the W-bit result is all zeros. Sign is the result MSB. Parity is set when the low result byte has an even number of ones.
- R12: Code 7 returns the destination and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (0 to 7, see the table above) |
| size_i | input | 2 | Operand size code; 2^code bytes |
| src_i | input | 64 | Source operand |
| cnt_i | input | 6 | Count operand |
| dest_i | input | 64 | Old destination value |
| flags_i | input | 6 | Incoming flags |
| wr_en_i | input | 6 | Flag-write mask, same layout as the flags |
| dest_o | output | 64 | Merged destination value |
| flags_o | output | 6 | Updated flags |

## Verification
The assertions assume known values on the operation and size inputs, and they are evaluated on settled combinational outputs. They take for granted that a zero count, a deselected flag or the no-op code leaves the corresponding outputs equal to the inputs, whatever the data. The stimulus changes all inputs together at one clock edge and samples half a period later, so every check sees settled values. It drives only defined values: every code, size and raw count from 0 to 63, a set of data patterns, and several carry-in and write-mask combinations.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int SR_XLEN      = 64;
    localparam int SR_CNT_W     = 6;
    localparam int SR_NUM_SIZES = 4;
    localparam int SR_SIZE_W    = $clog2(SR_NUM_SIZES);
    localparam int SR_FLAG_W    = 6;

    localparam int FL_CARRY  = 0;
    localparam int FL_XCARRY = 1;
    localparam int FL_PARITY = 2;
    localparam int FL_ZERO   = 3;
    localparam int FL_SIGN   = 4;
    localparam int FL_OVFL   = 5;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_SAR  = 3'd2,
        OP_ROR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_RCR  = 3'd5,
        OP_RCL  = 3'd6,
        OP_NONE = 3'd7
    } sr_op_e;

    typedef struct packed {
        logic [SR_XLEN-1:0] res;
        logic               cf;
        logic               of;
        logic               zf;
        logic               sf;
        logic               pf;
    } sr_lane_res_t;

endpackage

// File: rtl/sr_count_mask.sv
module sr_count_mask
    import sr_pkg::*;
#(
    parameter int CNT_W  = SR_CNT_W,
    parameter int SIZE_W = SR_SIZE_W
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]  eff_o,
    output logic              zero_o
);
    localparam logic [SIZE_W-1:0] WIDEST = SIZE_W'(SR_NUM_SIZES - 1);
    localparam logic [CNT_W-1:0]  MASK_WIDE   = CNT_W'(63);
    localparam logic [CNT_W-1:0]  MASK_NARROW = CNT_W'(31);

    always_comb begin
        eff_o  = cnt_i & ((size_i == WIDEST) ? MASK_WIDE : MASK_NARROW);
        zero_o = (eff_o == '0);
    end
endmodule

// File: rtl/sr_lane.sv
module sr_lane
    import sr_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = SR_CNT_W
) (
    input  sr_op_e          op_i,
    input  logic [W-1:0]    src_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic            cf_i,
    output sr_lane_res_t    res_o
);
    localparam int RW = $clog2(W);

    logic [2*W-1:0]   lsh;
    logic [2*W-1:0]   rsh_l;
    logic [2*W-1:0]   rsh_a;
    logic [2*W-1:0]   rot_r;
    logic [2*W-1:0]   rot_l;
    logic [W:0]       cv;
    logic [2*W+1:0]   rc_r;
    logic [2*W+1:0]   rc_l;
    logic [W:0]       rcr_v;
    logic [W:0]       rcl_v;
    logic [RW-1:0]    r_plain;
    int               r_carry;
    logic [W-1:0]     res;
    logic             cf;
    logic             of;

    // Shift paths: the extra half of each vector captures the last bit out.
    assign lsh     = {{W{1'b0}}, src_i} << cnt_i;
    assign rsh_l   = {src_i, {W{1'b0}}} >> cnt_i;
    assign rsh_a   = $signed({src_i, {W{1'b0}}}) >>> cnt_i;

    // Plain rotates: doubled operand, count taken modulo W.
    assign r_plain = cnt_i[RW-1:0];
    assign rot_r   = {src_i, src_i} >> r_plain;
    assign rot_l   = {src_i, src_i} << r_plain;

    // Through-carry rotates: (W+1)-bit ring, count modulo W+1.
    assign cv      = {cf_i, src_i};
    assign r_carry = int'(cnt_i) % (W + 1);
    assign rc_r    = {cv, cv} >> r_carry;
    assign rc_l    = {cv, cv} << r_carry;
    assign rcr_v   = rc_r[W:0];
    assign rcl_v   = rc_l[2*W+1:W+1];

    always_comb begin
        res = src_i;
        cf  = 1'b0;
        of  = 1'b0;
        unique case (op_i)
            OP_SHL: begin
                res = lsh[W-1:0];
                cf  = lsh[W];
                of  = lsh[W] ^ lsh[W-1];
            end
            OP_SHR: begin
                res = rsh_l[2*W-1:W];
                cf  = rsh_l[W-1];
                of  = src_i[W-1];
            end
            OP_SAR: begin
                res = rsh_a[2*W-1:W];
                cf  = rsh_a[W-1];
                of  = 1'b0;
            end
            OP_ROR: begin
                res = rot_r[W-1:0];
                cf  = rot_r[W-1];
                of  = rot_r[W-1] ^ rot_r[W-2];
            end
            OP_ROL: begin
                res = rot_l[2*W-1:W];
                cf  = rot_l[W];
                of  = rot_l[2*W-1] ^ rot_l[W];
            end
            OP_RCR: begin
                res = rcr_v[W-1:0];
                cf  = rcr_v[W];
                of  = cf_i ^ src_i[W-1];
            end
            OP_RCL: begin
                res = rcl_v[W-1:0];
                cf  = rcl_v[W];
                of  = rcl_v[W-1] ^ rcl_v[W];
            end
            OP_NONE: begin
                res = src_i;
                cf  = cf_i;
                of  = 1'b0;
            end
        endcase
    end

    always_comb begin
        res_o     = '0;
        res_o.res = SR_XLEN'(res);
        res_o.cf  = cf;
        res_o.of  = of;
        res_o.zf  = (res == '0);
        res_o.sf  = res[W-1];
        res_o.pf  = ~^res[7:0];
    end
endmodule

// File: rtl/sr_dest_merge.sv
module sr_dest_merge
    import sr_pkg::*;
#(
    parameter int XLEN   = SR_XLEN,
    parameter int SIZE_W = SR_SIZE_W
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic              wr_i,
    input  logic [XLEN-1:0]   res_i,
    input  logic [XLEN-1:0]   dest_i,
    output logic [XLEN-1:0]   dest_o
);
    localparam int NB  = XLEN / 8;
    localparam int NBW = $clog2(NB) + 1;

    logic [NBW-1:0] nbytes;
    logic [NB-1:0]  wr_byte;

    assign nbytes = NBW'(1) << size_i;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign wr_byte[b]      = wr_i && (NBW'(b) < nbytes);
        assign dest_o[8*b +: 8] = wr_byte[b] ? res_i[8*b +: 8] : dest_i[8*b +: 8];
    end
endmodule

// File: rtl/sr_flag_update.sv
module sr_flag_update
    import sr_pkg::*;
#(
    parameter int FLAG_W = SR_FLAG_W
) (
    input  logic               upd_i,
    input  sr_lane_res_t       lane_i,
    input  logic [FLAG_W-1:0]  flags_i,
    input  logic [FLAG_W-1:0]  wr_en_i,
    output logic [FLAG_W-1:0]  flags_o
);
    logic [FLAG_W-1:0] fresh;

    always_comb begin
        fresh            = '0;
        fresh[FL_CARRY]  = lane_i.cf;
        fresh[FL_XCARRY] = lane_i.cf;
        fresh[FL_PARITY] = lane_i.pf;
        fresh[FL_ZERO]   = lane_i.zf;
        fresh[FL_SIGN]   = lane_i.sf;
        fresh[FL_OVFL]   = lane_i.of;
        if (upd_i) begin
            flags_o = (flags_i & ~wr_en_i) | (fresh & wr_en_i);
        end else begin
            flags_o = flags_i;
        end
    end
endmodule

// File: rtl/sr_shift_rotate_unit.sv
module sr_shift_rotate_unit
    import sr_pkg::*;
#(
    parameter int DATA_W = SR_XLEN,
    parameter int CNT_W  = SR_CNT_W,
    parameter int FLAG_W = SR_FLAG_W,
    parameter int SIZE_W = SR_SIZE_W
) (
    input  logic [2:0]        op_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] dest_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [FLAG_W-1:0] wr_en_i,
    output logic [DATA_W-1:0] dest_o,
    output logic [FLAG_W-1:0] flags_o
);
    sr_op_e             op;
    logic [CNT_W-1:0]   eff_cnt;
    logic               cnt_zero;
    sr_lane_res_t       lane_q [SR_NUM_SIZES];
    sr_lane_res_t       sel;
    logic               is_rotate;
    logic               is_none;
    logic               dest_wr;
    logic               flag_upd;

    assign op = sr_op_e'(op_i);

    sr_count_mask #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_cnt (
        .size_i (size_i),
        .cnt_i  (cnt_i),
        .eff_o  (eff_cnt),
        .zero_o (cnt_zero)
    );

    for (genvar g = 0; g < SR_NUM_SIZES; g++) begin : g_lane
        localparam int LW = 8 << g;
        sr_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
            .op_i  (op),
            .src_i (src_i[LW-1:0]),
            .cnt_i (eff_cnt),
            .cf_i  (flags_i[FL_CARRY]),
            .res_o (lane_q[g])
        );
    end

    assign sel       = lane_q[size_i];
    assign is_none   = (op == OP_NONE);
    assign is_rotate = (op == OP_ROR) || (op == OP_ROL) ||
                       (op == OP_RCR) || (op == OP_RCL);
    assign dest_wr   = !is_none && !(cnt_zero && is_rotate);
    assign flag_upd  = !is_none && !cnt_zero;

    sr_dest_merge #(.XLEN(DATA_W), .SIZE_W(SIZE_W)) u_merge (
        .size_i (size_i),
        .wr_i   (dest_wr),
        .res_i  (sel.res),
        .dest_i (dest_i),
        .dest_o (dest_o)
    );

    sr_flag_update #(.FLAG_W(FLAG_W)) u_flags (
        .upd_i   (flag_upd),
        .lane_i  (sel),
        .flags_i (flags_i),
        .wr_en_i (wr_en_i),
        .flags_o (flags_o)
    );
endmodule

// File: rtl/sr_shift_rotate_chk.sv
module sr_shift_rotate_chk (
    input logic [2:0]  op_i,
    input logic [1:0]  size_i,
    input logic [7:0]  src_lo_i,
    input logic [5:0]  cnt_i,
    input logic [63:0] dest_i,
    input logic [5:0]  flags_i,
    input logic [5:0]  wr_en_i,
    input logic [63:0] dest_o,
    input logic [5:0]  flags_o
);
    logic [5:0] eff;
    logic       nz;

    always_comb begin
        eff = (size_i == 2'd3) ? cnt_i : (cnt_i & 6'd31);
        nz  = (eff != 6'd0);

        AST_ZERO_CNT_FLAGS: assert (nz || flags_o == flags_i); // R2
        AST_ZERO_CNT_ROT_DEST: assert (nz || op_i < 3'd3 || dest_o == dest_i); // R2
        AST_ZERO_CNT_SHIFT_DEST: assert (nz || op_i > 3'd2 || dest_o[7:0] == src_lo_i); // R2
        AST_HIGH_BYTES_KEPT: assert (size_i != 2'd0 || dest_o[63:8] == dest_i[63:8]); // R3
        AST_UNSEL_FLAGS_KEPT: assert (((flags_o ^ flags_i) & ~wr_en_i) == 6'd0); // R4
        AST_XCARRY_TRACKS_CARRY: assert (!(nz && op_i != 3'd7 && wr_en_i[0] && wr_en_i[1]) || flags_o[0] == flags_o[1]); // R4
        AST_SAR_OVFL_CLEAR: assert (!(nz && op_i == 3'd2 && wr_en_i[5]) || !flags_o[5]); // R7
        AST_NOOP_PASS: assert (op_i != 3'd7 || (dest_o == dest_i && flags_o == flags_i)); // R12
    end
endmodule

bind sr_shift_rotate_unit sr_shift_rotate_chk u_chk (
    .op_i     (op_i),
    .size_i   (size_i),
    .src_lo_i (src_i[7:0]),
    .cnt_i    (cnt_i),
    .dest_i   (dest_i),
    .flags_i  (flags_i),
    .wr_en_i  (wr_en_i),
    .dest_o   (dest_o),
    .flags_o  (flags_o)
);

// File: tb/tb_sr_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_sr_shift_rotate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i;
    logic [1:0]  size_i;
    logic [63:0] src_i;
    logic [5:0]  cnt_i;
    logic [63:0] dest_i;
    logic [5:0]  flags_i;
    logic [5:0]  wr_en_i;
    logic [63:0] dest_o;
    logic [5:0]  flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sr_shift_rotate_unit dut (
        .op_i    (op_i),
        .size_i  (size_i),
        .src_i   (src_i),
        .cnt_i   (cnt_i),
        .dest_i  (dest_i),
        .flags_i (flags_i),
        .wr_en_i (wr_en_i),
        .dest_o  (dest_o),
        .flags_o (flags_o)
    );

    task automatic model(input int op, input int size, input logic [63:0] src,
                         input logic [5:0] cnt, input logic [63:0] dest,
                         input logic [5:0] fl, input logic [5:0] en,
                         output logic [63:0] eo, output logic [5:0] fo);
        int w = 8 << size;
        int c = (size == 3) ? int'(cnt) : int'(cnt & 6'd31);
        logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        logic [63:0] v = src & m;
        logic sgn = v[w-1];
        logic cc = fl[0];
        logic nc = 1'b0;
        logic of = 1'b0;
        logic t;
        logic [5:0] nf;
        case (op)
            0: begin
                for (int i = 0; i < c; i++) begin nc = v[w-1]; v = (v << 1) & m; end
                of = nc ^ v[w-1];
            end
            1: begin
                for (int i = 0; i < c; i++) begin nc = v[0]; v = v >> 1; end
                of = src[w-1];
            end
            2: begin
                for (int i = 0; i < c; i++) begin nc = v[0]; v = (v >> 1) | (64'(sgn) << (w-1)); end
                of = 1'b0;
            end
            3: begin
                for (int i = 0; i < c; i++) v = (v >> 1) | (64'(v[0]) << (w-1));
                nc = v[w-1]; of = v[w-1] ^ v[w-2];
            end
            4: begin
                for (int i = 0; i < c; i++) v = ((v << 1) & m) | 64'(v[w-1]);
                nc = v[0]; of = v[w-1] ^ v[0];
            end
            5: begin
                for (int i = 0; i < c; i++) begin t = v[0]; v = (v >> 1) | (64'(cc) << (w-1)); cc = t; end
                nc = cc; of = fl[0] ^ src[w-1];
            end
            6: begin
                for (int i = 0; i < c; i++) begin t = v[w-1]; v = ((v << 1) & m) | 64'(cc); cc = t; end
                nc = cc; of = v[w-1] ^ nc;
            end
            default: ;
        endcase
        if (op == 7 || (c == 0 && op >= 3)) eo = dest;
        else eo = (dest & ~m) | (v & m);
        nf = {of, v[w-1], ((v & m) == 64'd0), ~^v[7:0], nc, nc};
        if (op == 7 || c == 0) fo = fl;
        else fo = (fl & ~en) | (nf & en);
    endtask

    function automatic string tag_of(int op, int c);
        if (op == 7) return "R12";
        if (c == 0) return "R2";
        case (op)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            3, 4: return "R8";
            5: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (op=%0d size=%0d cnt=%0d src=%h)",
                     tag, act, exp, op_i, size_i, cnt_i, src_i);
        end
    endtask

    task automatic apply(input int op, input int size, input logic [63:0] src,
                         input logic [5:0] cnt, input logic [63:0] dest,
                         input logic [5:0] fl, input logic [5:0] en);
        @(posedge clk);
        op_i = 3'(op); size_i = 2'(size); src_i = src; cnt_i = cnt;
        dest_i = dest; flags_i = fl; wr_en_i = en;
        @(negedge clk);
    endtask

    task automatic run_vec(input int op, input int size, input logic [63:0] src,
                           input logic [5:0] cnt, input logic [63:0] dest,
                           input logic [5:0] fl, input logic [5:0] en, input string extra);
        logic [63:0] eo;
        logic [5:0] fo;
        int c = (size == 3) ? int'(cnt) : int'(cnt & 6'd31);
        string tg = tag_of(op, c);
        apply(op, size, src, cnt, dest, fl, en);
        model(op, size, src, cnt, dest, fl, en, eo, fo);
        chk({tg, extra, " dest"}, dest_o, eo);
        chk({tg, extra, " flags R4 R11"}, 64'(flags_o), 64'(fo));
    endtask

    initial begin
        logic [63:0] pats [4];
        logic [5:0] fls [3];
        logic [5:0] ens [3];
        pats[0] = 64'hDEAD_BEEF_8BAD_F00D;
        pats[1] = 64'h0123_4567_89AB_CD80;
        pats[2] = 64'h8000_7FFF_0001_00FF;
        pats[3] = 64'h5555_AAAA_3C3C_C3C3;
        fls[0] = 6'b000000; ens[0] = 6'b111111;
        fls[1] = 6'b011101; ens[1] = 6'b101011;
        fls[2] = 6'b111111; ens[2] = 6'b111111;

        op_i = '0; size_i = '0; src_i = '0; cnt_i = '0;
        dest_i = '0; flags_i = '0; wr_en_i = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // reset state: all-zero inputs give zero outputs (R2)
        chk("R2 reset dest", dest_o, 64'd0);
        chk("R2 reset flags", 64'(flags_o), 64'd0);
        rst_n = 1'b1;

        // R1: count 32 masks to 0 at one byte, stays 32 at eight bytes
        run_vec(0, 0, 64'h0000_0000_0000_00A5, 6'd32, 64'hFFFF_FFFF_FFFF_FFFF, 6'b100001, 6'b111111, " R1 narrow");
        chk("R1 narrow unshifted", dest_o, 64'hFFFF_FFFF_FFFF_FFA5);
        run_vec(0, 3, 64'h0000_0000_8000_0001, 6'd32, 64'd0, 6'd0, 6'b111111, " R1 wide");
        chk("R1 wide shifted", dest_o, 64'h8000_0001_0000_0000);

        // R3: two-byte write keeps upper six bytes
        run_vec(0, 1, 64'd0, 6'd1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 6'd0, " R3");
        chk("R3 upper bytes", dest_o, 64'hFFFF_FFFF_FFFF_0000);

        // R4: empty mask, nonzero count, flags untouched
        run_vec(1, 2, 64'hFFFF_FFFF, 6'd3, 64'd0, 6'b101010, 6'd0, " R4");
        chk("R4 masked flags", 64'(flags_o), 64'(6'b101010));

        // R11: byte shift leaving zero -> zero=1, parity=1, sign=0, carry=1
        run_vec(0, 0, 64'h80, 6'd1, 64'd0, 6'd0, 6'b111111, " R11");
        chk("R11 flag values", 64'(flags_o), 64'(6'b101111));

        // Sweep: every code, size and raw count over patterns and flag setups
        for (int op = 0; op < 8; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int cn = 0; cn < 64; cn++)
                    for (int p = 0; p < 4; p++)
                        for (int md = 0; md < 3; md++)
                            run_vec(op, sz, pats[p], 6'(cn), 64'hCAFE_F00D_1234_5678,
                                    fls[md], ens[md], " sweep");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R12 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule